// File: doc/BRIEF.md
# Priority Interrupt Vector Controller

This block watches sixteen external interrupt lines and turns their activity into a single interrupt request and a vector code for the processor. Every line is synchronized to the block clock and passed to an edge detector whose sensitivity is set per line. Lines can trigger on a falling edge only or on both edges. A detected edge sets a sticky pending bit. Software clears a pending bit by writing one to it. A per-line enable register decides which pending bits may reach the processor. The request output is high while any enabled pending bit is set.

The vector code names the enabled pending line with the highest priority. The code is (line+1)*4, so its two low bits are always zero. Software can therefore add it straight to a jump table base. A byte read returns the code itself, which suits a table of 4-byte branch entries. A half-word read returns the code shifted left by eight, which suits a table of 1 KB routine slots. A word read returns the code in the top byte.

Registers are reached over a stream-style request/response pair. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no read response is waiting, or when the waiting response is being taken that cycle. A read produces one response. The response data is captured when the request is accepted and is held until `rsp_ready` takes it. The returned vector therefore cannot change during the access. Writes produce no response.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `rsp_valid` is 0, `req_ready` is 1, and the pending, enable and edge-mode registers all read 0.
- R2: The edge-mode register is at byte offset 0xC, with bit n for line n. When bit n is 0, a high-to-low change on line n sets pending bit n, and a low-to-high change sets nothing.
- R3: When edge-mode bit n is 1, both a rising and a falling change on line n set pending bit n.
- R4: The pending register at offset 0x4 is sticky. Writing it clears each bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If an edge sets pending bit n in the same cycle that a write clears bit n, the bit ends up set.
- R6: The enable register at offset 0x8 holds one bit per line, where 1 means the line is unmasked. `irq` is the OR of all pending bits that are enabled. A masked pending bit still reads back in the pending register.
- R7: The vector code is (n+1)*4 for the lowest-numbered line n that is both pending and enabled, or 0 when no such line exists. Its two low bits are always 0.
- R8: A read of offset 0x0 returns the vector code according to `req_size`. Size 0 (byte) gives the code in bits 7:0. Size 1 (half word) gives the code times 256. Sizes 2 and 3 (word) give the code in bits 31:24. All other bits are 0.
- R9: Read data is taken at request acceptance. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` stay unchanged, even if a higher-priority line becomes pending.
- R10: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. An accepted read raises `rsp_valid` on the next cycle. An accepted write raises no response.
- R11: A change on an input line appears in the pending register, and in `irq` if the line is enabled, after the third rising clock edge following the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_lines | input | 16 | External interrupt lines, asynchronous |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset; bits 3:2 select the register |
| req_size | input | 2 | Read width: 0 byte, 1 half word, 2/3 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Combined interrupt request |

## Verification
Two collisions are provoked on purpose.

The first is a clear and a set of the same pending bit. The bench releases a line change and times a write-one-to-clear so that it is accepted on exactly the third edge after the change. It then expects the bit to read back as set.

The second is a new higher-priority edge during a held vector read. The bench stalls `rsp_ready` after a vector read has been accepted and then drops line 0. It expects the old code to stay on `rsp_rdata` for the whole stall. It expects the new code on the following read.

A behavioural reference model, stepped on every clock, judges `irq`, `req_ready`, `rsp_valid` and the response data throughout.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // Register index, taken from req_addr[3:2]
  localparam logic [1:0] RIDX_VECTOR = 2'd0;
  localparam logic [1:0] RIDX_PEND   = 2'd1;
  localparam logic [1:0] RIDX_ENABLE = 2'd2;
  localparam logic [1:0] RIDX_MODE   = 2'd3;

  // Read width codes
  localparam logic [1:0] RSZ_BYTE = 2'd0;
  localparam logic [1:0] RSZ_HALF = 2'd1;

  // Spacing of vector codes: keeps the two low bits zero
  localparam int CODE_STEP = 4;
endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  // Idle level of the lines is high, so the stages reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ivc_edge_pend.sv
module ivc_edge_pend #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] any_edge,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] set_vec;

  // Per-line edge sensitivity
  for (genvar i = 0; i < N; i++) begin : g_line
    assign set_vec[i] = any_edge[i] ? (cur[i] ^ prev_q[i])
                                    : (prev_q[i] & ~cur[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      prev_q <= cur;
      // A new edge overrides a simultaneous clear
      pend_q <= (pend_q & ~clr) | set_vec;
    end
  end

  assign pend = pend_q;

  // R5: a detected edge always leaves its bit set
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R4: without a clear, pending bits never drop
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int N      = 16,
  parameter int CODE_W = 8
) (
  input  logic [N-1:0]      req,
  output logic [CODE_W-1:0] code
);
  import ivc_pkg::*;

  // Scan from the lowest priority upward so line 0 wins
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = CODE_W'((i + 1) * CODE_STEP);
    end
  end
endmodule

// File: rtl/ivc_regs.sv
module ivc_regs #(
  parameter int N      = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [N-1:0]      pend,
  input  logic [CODE_W-1:0] code,
  output logic [N-1:0]      enable,
  output logic [N-1:0]      any_edge,
  output logic [N-1:0]      clr
);
  import ivc_pkg::*;

  localparam int TOP_SHIFT  = DATA_W - CODE_W;
  localparam int HALF_SHIFT = 8;

  logic              acc;
  logic [1:0]        idx;
  logic [DATA_W-1:0] rd_data;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [N-1:0]      en_q;
  logic [N-1:0]      mode_q;
  logic              wdata_unused;

  assign idx          = req_addr[3:2];
  assign req_ready    = !rsp_valid_q || rsp_ready;
  assign acc          = req_valid && req_ready;
  assign wdata_unused = ^{req_wdata[DATA_W-1:N], req_addr[1:0]};

  always_comb begin
    rd_data = '0;
    case (idx)
      RIDX_VECTOR: begin
        if (req_size == RSZ_BYTE)      rd_data = DATA_W'(code);
        else if (req_size == RSZ_HALF) rd_data = DATA_W'(code) << HALF_SHIFT;
        else                           rd_data = DATA_W'(code) << TOP_SHIFT;
      end
      RIDX_PEND:   rd_data = DATA_W'(pend);
      RIDX_ENABLE: rd_data = DATA_W'(en_q);
      default:     rd_data = DATA_W'(mode_q);
    endcase
  end

  assign clr = (acc && req_write && idx == RIDX_PEND) ? req_wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      en_q        <= '0;
      mode_q      <= '0;
    end else begin
      if (acc && !req_write) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_data;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
      if (acc && req_write && idx == RIDX_ENABLE) en_q   <= req_wdata[N-1:0];
      if (acc && req_write && idx == RIDX_MODE)   mode_q <= req_wdata[N-1:0];
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign enable    = en_q;
  assign any_edge  = mode_q;

  // R9: a stalled response holds still
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready) |=> (rsp_valid_q && $stable(rsp_data_q)));

  // R10: a write never creates a response
  p_write_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !rsp_valid_q) |=> !rsp_valid_q);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] int_lines,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               irq
);
  localparam int CODE_W = 8;

  logic [N_LINES-1:0] synced;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] enable;
  logic [N_LINES-1:0] any_edge;
  logic [N_LINES-1:0] clr;
  logic [N_LINES-1:0] live;
  logic [CODE_W-1:0]  code;

  ivc_sync #(.W(N_LINES), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(int_lines), .q(synced)
  );

  ivc_edge_pend #(.N(N_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .cur(synced), .any_edge(any_edge),
    .clr(clr), .pend(pend)
  );

  assign live = pend & enable;
  assign irq  = |live;

  ivc_prio #(.N(N_LINES), .CODE_W(CODE_W)) u_prio (
    .req(live), .code(code)
  );

  ivc_regs #(.N(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pend(pend), .code(code), .enable(enable), .any_edge(any_edge), .clr(clr)
  );

  // R6/R7: a request is raised exactly when a nonzero code exists
  p_irq_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != '0));

  // R7: codes keep their two low bits clear
  p_code_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code[1:0] == 2'b00);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] int_lines = 16'hFFFF;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .int_lines(int_lines),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_hist [$];
  logic [15:0] m_last, m_pend, m_en, m_mode, m_clr, m_edge, m_now;
  logic        m_rv;
  logic [31:0] m_rd;
  logic        m_acc;

  function automatic logic [31:0] m_read(input logic [1:0] ri, input logic [1:0] sz,
                                         input logic [15:0] p, input logic [15:0] e,
                                         input logic [15:0] md);
    int c;
    c = 0;
    for (int i = 15; i >= 0; i--) if (p[i] && e[i]) c = (i + 1) * 4;
    case (ri)
      2'd0: m_read = (sz == 0) ? 32'(c) : (sz == 1) ? 32'(c) << 8 : 32'(c) << 24;
      2'd1: m_read = {16'h0, p};
      2'd2: m_read = {16'h0, e};
      default: m_read = {16'h0, md};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = {16'hFFFF, 16'hFFFF};
      m_last = 16'hFFFF;
      m_pend = '0; m_en = '0; m_mode = '0; m_rv = 0; m_rd = '0;
    end else begin
      m_acc = req_valid && (!m_rv || rsp_ready);
      m_clr = (m_acc && req_write && req_addr[3:2] == 2'd1) ? req_wdata[15:0] : '0;
      m_now = m_hist[0]; // value that has crossed the synchronizer
      for (int i = 0; i < 16; i++)
        m_edge[i] = m_mode[i] ? (m_now[i] != m_last[i]) : (m_last[i] && !m_now[i]);
      if (m_acc && !req_write) begin
        m_rv = 1;
        m_rd = m_read(req_addr[3:2], req_size, m_pend, m_en, m_mode);
      end else if (rsp_ready) m_rv = 0;
      if (m_acc && req_write && req_addr[3:2] == 2'd2) m_en = req_wdata[15:0];
      if (m_acc && req_write && req_addr[3:2] == 2'd3) m_mode = req_wdata[15:0];
      m_pend = (m_pend & ~m_clr) | m_edge;
      m_last = m_now;
      void'(m_hist.pop_front());
      m_hist.push_back(int_lines);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6 irq vs model", {31'b0, irq}, {31'b0, |(m_pend & m_en)});
      chk("R10 req_ready vs model", {31'b0, req_ready}, {31'b0, !m_rv || rsp_ready});
      chk("R9 rsp_valid vs model", {31'b0, rsp_valid}, {31'b0, m_rv});
      if (m_rv) chk("R8 rsp_rdata vs model", rsp_rdata, m_rd);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int ri, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 4'(ri * 4); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input int ri, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 4'(ri * 4); req_size = sz;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    ticks(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq at reset", {31'b0, irq}, 32'd0);
    chk("R1 rsp_valid at reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 req_ready at reset", {31'b0, req_ready}, 32'd1);
    bus_read(1, 2, d); chk("R1 pending at reset", d, 32'h0);
    bus_read(2, 2, d); chk("R1 enable at reset", d, 32'h0);
    bus_read(3, 2, d); chk("R1 mode at reset", d, 32'h0);

    // R10: a write raises no response
    bus_write(2, 32'h0000_FFFF);
    chk("R10 no response after write", {31'b0, rsp_valid}, 32'd0);

    // R11 / R2: falling edge on line 7
    @(negedge clk); int_lines[7] = 0;
    @(negedge clk); chk("R11 irq after 1 edge", {31'b0, irq}, 32'd0);
    @(negedge clk); chk("R11 irq after 2 edges", {31'b0, irq}, 32'd0);
    @(negedge clk); chk("R11 irq after 3 edges", {31'b0, irq}, 32'd1);
    bus_read(0, 2, d); chk("R8 word vector line 7", d, 32'd32 << 24);
    bus_read(0, 0, d); chk("R8 byte vector line 7", d, 32'd32);
    bus_read(0, 1, d); chk("R8 half vector line 7", d, 32'd32 << 8);
    bus_read(0, 3, d); chk("R8 size 3 vector line 7", d, 32'd32 << 24);

    // R2 rising ignored, R4 clear
    bus_write(1, 32'h0000_0080);
    int_lines[7] = 1; ticks(5);
    bus_read(1, 2, d); chk("R2 rising edge ignored in falling mode", d, 32'h0);

    // R4: writing zero keeps bits
    int_lines[9] = 0; ticks(5);
    bus_write(1, 32'h0);
    bus_read(1, 2, d); chk("R4 zero write keeps pending", d, 32'h0000_0200);
    bus_write(1, 32'h0000_0200);
    bus_read(1, 2, d); chk("R4 one write clears pending", d, 32'h0);
    int_lines[9] = 1; ticks(5);

    // R3: any-edge mode on line 3
    bus_write(3, 32'h0000_0008);
    int_lines[3] = 0; ticks(5);
    bus_read(1, 2, d); chk("R3 falling in any-edge mode", d, 32'h0000_0008);
    bus_write(1, 32'h0000_0008);
    int_lines[3] = 1; ticks(5);
    bus_read(1, 2, d); chk("R3 rising in any-edge mode", d, 32'h0000_0008);
    bus_write(1, 32'h0000_0008);

    // R6 / R7: masking and priority
    bus_write(2, 32'h0);
    int_lines[2] = 0; ticks(5);
    chk("R6 masked pending gives no irq", {31'b0, irq}, 32'd0);
    bus_read(1, 2, d); chk("R6 masked pending still visible", d, 32'h0000_0004);
    bus_read(0, 0, d); chk("R7 no enabled source gives code 0", d, 32'd0);
    bus_write(2, 32'h0000_0004);
    ticks(1); chk("R6 irq once unmasked", {31'b0, irq}, 32'd1);
    bus_read(0, 0, d); chk("R7 code for line 2", d, 32'd12);
    int_lines[1] = 0; ticks(5);
    bus_read(0, 0, d); chk("R7 masked higher line ignored", d, 32'd12);
    bus_write(2, 32'h0000_FFFF);
    bus_read(0, 0, d); chk("R7 line 1 beats line 2", d, 32'd8);
    int_lines[1] = 1; int_lines[2] = 1; ticks(5);
    bus_write(1, 32'h0000_FFFF);
    bus_read(0, 0, d); chk("R7 cleared gives code 0", d, 32'd0);

    // R5: set and clear of line 3 in the same cycle
    int_lines[3] = 0; ticks(5);
    @(negedge clk); int_lines[3] = 1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 4'h4; req_wdata = 32'h0000_0008;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    bus_read(1, 2, d); chk("R5 set wins over clear", d, 32'h0000_0008);
    bus_write(1, 32'h0000_0008);
    bus_read(1, 2, d); chk("R5 later clear works", d, 32'h0);

    // R9: held vector during a stalled response
    int_lines[5] = 0; ticks(5);
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 4'h0; req_size = 2;
    @(negedge clk);
    req_valid = 0;
    int_lines[0] = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R9 held valid", {31'b0, rsp_valid}, 32'd1);
      chk("R9 held vector", rsp_rdata, 32'd24 << 24);
      chk("R10 not ready while stalled", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R10 response taken", {31'b0, rsp_valid}, 32'd0);
    bus_read(0, 2, d); chk("R9 new code after release", d, 32'd4 << 24);

    ticks(3);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule